// File: doc/BRIEF.md
# Burst and Continuous Bitstream Capture Controller

This block controls when the single-bit output of a sigma-delta modulator is captured. Software reaches it through a simple memory-mapped register port. Through that port it sets the operating mode, the number of bits in a burst, the run bit, the interrupt enable and the hold-in-reset controls for the analog sections, and it reads back status. The modulator itself is not part of the block. Each bit it delivers appears as a single-cycle `bit_valid` strobe, and the `capture_en` output tells the modulator and the downstream filter that a capture is in progress.

There are two modes. In burst mode, every strobe received while running advances a bit counter. When the counter reaches the programmed total, the block stops itself, sets a done flag and can raise an interrupt. Software acknowledges the done flag simply by reading the status register. In continuous mode the capture keeps going until software writes the run bit back to zero, and the done flag is never raised.

Top module: `bsc_capture_ctrl`

## Requirements
- R1: After reset, every register reads 0, and `capture_en`, `mod_rst`, `amp_rst` and `irq` are all 0.
- R2: Register offsets are: control 0x00, divider 0x04, burst total 0x08, run 0x0C, interrupt enable 0x10, status 0x14. Control keeps bits 2:0, the divider keeps bits 7:0, the total keeps bits 19:0, and run and interrupt enable each keep bit 0. Bits that are not kept read as 0. Status is read-only, and writes to it have no effect.
- R3: In burst mode (control bit 0 = 0), `capture_en` (which is run bit 0) drops in the cycle after the strobe that brings the bit count up to the total. A total of 0 behaves like a total of 1.
- R4: In continuous mode (control bit 0 = 1), the run bit never clears by itself, however many strobes arrive. Only a software write of 0 stops the capture.
- R5: Status bit 0 (done) sets when a burst completes. It never sets in continuous mode.
- R6: A status read while done is set clears done. If the read happens in the same cycle that a burst completes, it returns done = 1 and done stays set.
- R7: `irq` is high exactly when done is set and interrupt-enable bit 0 is 1.
- R8: Control bit 1 drives `mod_rst` and control bit 2 drives `amp_rst`. Each stays at its written value until software rewrites the control register. Status bit 1 reads 1 while either of them is high.
- R9: Each 0-to-1 change of the run bit restarts the bit count from zero, so a burst that was stopped early and then restarted still needs the full total.
- R10: Writing 1 to the run bit while it is already 1 does not restart the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (reading status has a side effect) |
| reg_addr | input | 5 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the current address |
| bit_valid | input | 1 | One modulator bit delivered this cycle |
| capture_en | output | 1 | Capture running (run bit) |
| mod_rst | output | 1 | Hold modulator in reset |
| amp_rst | output | 1 | Hold amplifier in reset |
| irq | output | 1 | Burst-done interrupt |

## Verification
Some rules are checked by assertions on every cycle. After a completing strobe, done sets and the run bit drops unless software wrote run in the same cycle. Continuous mode never loses its run bit on its own and never raises done. A status read clears done unless a new completion arrives in that cycle. The interrupt never fires without its enable. The reset hold outputs move only on a control write. Other behaviours need the bench's scenarios, because they depend on how long a sequence is: that exactly N strobes end a burst, that a total of 0 stops after one bit, that a stop followed by a restart needs the full count again, that re-writing run while it is already 1 changes nothing, and the readback masking of each register.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 20;
    localparam int DIV_W  = 8;

    localparam int OFS_CTRL  = 'h00;
    localparam int OFS_DIV   = 'h04;
    localparam int OFS_TOTAL = 'h08;
    localparam int OFS_RUN   = 'h0C;
    localparam int OFS_IEN   = 'h10;
    localparam int OFS_STAT  = 'h14;

    // control register layout: bit0 continuous, bit1 modulator hold, bit2 amplifier hold
    typedef struct packed {
        logic amp_hold;
        logic mod_hold;
        logic cont;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // status register layout: bit0 done, bit1 analog held in reset
    typedef struct packed {
        logic ana_rst;
        logic done;
    } stat_t;

    function automatic ctrl_t to_ctrl(input logic [CTRL_W-1:0] raw);
        return ctrl_t'(raw);
    endfunction
endpackage

// File: rtl/bsc_regs.sv
module bsc_regs
    import bsc_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int CW  = CNT_W,
    parameter int DW8 = DIV_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [CW-1:0] wdata,
    output ctrl_t         ctrl_q,
    output logic [DW8-1:0] div_q,
    output logic [CW-1:0] total_q,
    output logic          irq_en_q
);
    localparam logic [AW-1:0] A_CTRL  = AW'(OFS_CTRL);
    localparam logic [AW-1:0] A_DIV   = AW'(OFS_DIV);
    localparam logic [AW-1:0] A_TOTAL = AW'(OFS_TOTAL);
    localparam logic [AW-1:0] A_IEN   = AW'(OFS_IEN);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            div_q    <= '0;
            total_q  <= '0;
            irq_en_q <= 1'b0;
        end else if (wr) begin
            if (addr == A_CTRL)  ctrl_q   <= to_ctrl(wdata[CTRL_W-1:0]);
            if (addr == A_DIV)   div_q    <= wdata[DW8-1:0];
            if (addr == A_TOTAL) total_q  <= wdata;
            if (addr == A_IEN)   irq_en_q <= wdata[0];
        end
    end
endmodule

// File: rtl/bsc_burst_seq.sv
module bsc_burst_seq
    import bsc_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run_wr,
    input  logic          run_wbit,
    input  logic          cont,
    input  logic [CW-1:0] total,
    input  logic          bit_valid,
    input  logic          stat_rd,
    output logic          run_q,
    output logic          done_q,
    output logic          complete
);
    logic [CW-1:0] cnt_q;
    logic [CW:0]   cnt_inc;
    logic          start_edge;
    logic          counting;

    assign cnt_inc    = {1'b0, cnt_q} + 1'b1;
    assign counting   = run_q & ~cont & bit_valid;
    assign complete   = counting & (cnt_inc >= {1'b0, total});
    assign start_edge = run_wr & run_wbit & ~run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            done_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            // software write has priority over the hardware stop
            if (run_wr)        run_q <= run_wbit;
            else if (complete) run_q <= 1'b0;

            if (start_edge || complete) cnt_q <= '0;
            else if (counting)          cnt_q <= cnt_inc[CW-1:0];

            // a new completion wins over the clearing read
            if (complete)                done_q <= 1'b1;
            else if (stat_rd && done_q)  done_q <= 1'b0;
        end
    end
endmodule

// File: rtl/bsc_capture_ctrl.sv
module bsc_capture_ctrl
    import bsc_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int DW  = DATA_W,
    parameter int CW  = CNT_W,
    parameter int DW8 = DIV_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          bit_valid,
    output logic          capture_en,
    output logic          mod_rst,
    output logic          amp_rst,
    output logic          irq
);
    localparam logic [AW-1:0] A_CTRL  = AW'(OFS_CTRL);
    localparam logic [AW-1:0] A_DIV   = AW'(OFS_DIV);
    localparam logic [AW-1:0] A_TOTAL = AW'(OFS_TOTAL);
    localparam logic [AW-1:0] A_RUN   = AW'(OFS_RUN);
    localparam logic [AW-1:0] A_IEN   = AW'(OFS_IEN);
    localparam logic [AW-1:0] A_STAT  = AW'(OFS_STAT);

    ctrl_t          ctrl_q;
    logic [DW8-1:0] div_q;
    logic [CW-1:0]  total_q;
    logic           irq_en_q;
    logic           run_q, done_q, complete;
    logic           run_wr, stat_rd, ctrl_wr;
    stat_t          stat;
    logic           unused_wbits;

    assign unused_wbits = ^reg_wdata[DW-1:CW];
    assign run_wr  = reg_wr && (reg_addr == A_RUN);
    assign ctrl_wr = reg_wr && (reg_addr == A_CTRL);
    assign stat_rd = reg_rd && (reg_addr == A_STAT);

    bsc_regs #(.AW(AW), .CW(CW), .DW8(DW8)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata[CW-1:0]),
        .ctrl_q   (ctrl_q),
        .div_q    (div_q),
        .total_q  (total_q),
        .irq_en_q (irq_en_q)
    );

    bsc_burst_seq #(.CW(CW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .run_wr    (run_wr),
        .run_wbit  (reg_wdata[0]),
        .cont      (ctrl_q.cont),
        .total     (total_q),
        .bit_valid (bit_valid),
        .stat_rd   (stat_rd),
        .run_q     (run_q),
        .done_q    (done_q),
        .complete  (complete)
    );

    assign stat.done    = done_q | complete;
    assign stat.ana_rst = ctrl_q.mod_hold | ctrl_q.amp_hold;

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CTRL:  reg_rdata = DW'(ctrl_q);
            A_DIV:   reg_rdata = DW'(div_q);
            A_TOTAL: reg_rdata = DW'(total_q);
            A_RUN:   reg_rdata = DW'(run_q);
            A_IEN:   reg_rdata = DW'(irq_en_q);
            A_STAT:  reg_rdata = DW'(stat);
            default: reg_rdata = '0;
        endcase
    end

    assign capture_en = run_q;
    assign mod_rst    = ctrl_q.mod_hold;
    assign amp_rst    = ctrl_q.amp_hold;
    assign irq        = done_q & irq_en_q;
endmodule

// File: rtl/bsc_capture_chk.sv
module bsc_capture_chk (
    input logic clk,
    input logic rst,
    input logic run_wr,
    input logic stat_rd,
    input logic ctrl_wr,
    input logic complete,
    input logic cont,
    input logic run,
    input logic done,
    input logic irq_en,
    input logic irq,
    input logic mod_rst
);
    AST_STOP_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        (complete && !run_wr) |=> (!run && done)); // R3
    AST_CONT_HOLDS_RUN: assert property (@(posedge clk) disable iff (rst)
        (run && cont && !run_wr) |=> run); // R4
    AST_DONE_BURST_ONLY: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> !$past(cont)); // R5
    AST_DONE_KEPT_ON_HIT: assert property (@(posedge clk) disable iff (rst)
        complete |=> done); // R6
    AST_READ_CLEARS_DONE: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && done && !complete) |=> !done); // R6
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        irq |-> irq_en); // R7
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        !ctrl_wr |=> $stable(mod_rst)); // R8
endmodule

bind bsc_capture_ctrl bsc_capture_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .run_wr   (run_wr),
    .stat_rd  (stat_rd),
    .ctrl_wr  (ctrl_wr),
    .complete (complete),
    .cont     (ctrl_q.cont),
    .run      (run_q),
    .done     (done_q),
    .irq_en   (irq_en_q),
    .irq      (irq),
    .mod_rst  (mod_rst)
);

// File: tb/bsc_capture_ctrl_test.sv
`timescale 1ns/1ps
module bsc_capture_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0, bit_valid = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        capture_en, mod_rst, amp_rst, irq;
    int          n_chk = 0, n_bad = 0;
    logic        finished = 1'b0;
    logic [31:0] rv;

    always #2 clk = ~clk;

    bsc_capture_ctrl uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bit_valid(bit_valid), .capture_en(capture_en), .mod_rst(mod_rst),
        .amp_rst(amp_rst), .irq(irq)
    );

    typedef struct packed {
        logic [4:0]  addr;
        logic [31:0] wdata;
        logic [31:0] expect_rd;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{5'h00, 32'hFFFF_FFF9, 32'h0000_0001},
        '{5'h04, 32'h1234_56A5, 32'h0000_00A5},
        '{5'h08, 32'hFFF1_2345, 32'h0001_2345},
        '{5'h10, 32'hFFFF_FFFE, 32'h0000_0000},
        '{5'h10, 32'h0000_0003, 32'h0000_0001},
        '{5'h14, 32'hFFFF_FFFF, 32'h0000_0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp_v);
        end
    endtask

    // one bus cycle: drive at negedge, sample read data before the edge
    task automatic cyc(input logic w, input logic r, input logic [4:0] a,
                       input logic [31:0] d, input logic bv, output logic [31:0] rd_o);
        @(negedge clk);
        reg_wr = w; reg_rd = r; reg_addr = a; reg_wdata = d; bit_valid = bv;
        #1 rd_o = reg_rdata;
        @(posedge clk);
        #0.5;
        reg_wr = 1'b0; reg_rd = 1'b0; bit_valid = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        logic [31:0] dummy;
        cyc(1'b1, 1'b0, a, d, 1'b0, dummy);
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        cyc(1'b0, 1'b1, a, 32'h0, 1'b0, d);
    endtask

    task automatic strobes(input int n);
        logic [31:0] dummy;
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 5'h00, 32'h0, 1'b1, dummy);
    endtask

    task automatic settle;
        @(negedge clk); #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        settle();
        chk("R1 outputs", {28'h0, capture_en, mod_rst, amp_rst, irq}, 32'h0);
        for (int a = 0; a < 6; a++) begin
            rd(5'(a * 4), rv);
            chk("R1 register", rv, 32'h0);
        end

        // R2 register map and masking
        for (int i = 0; i < NV; i++) begin
            wr(VECS[i].addr, VECS[i].wdata);
            rd(VECS[i].addr, rv);
            chk("R2 readback", rv, VECS[i].expect_rd);
        end
        wr(5'h00, 32'h0);

        // R8 reset holds
        wr(5'h00, 32'h2);
        repeat (3) strobes(1);
        settle();
        chk("R8 mod hold", {30'h0, mod_rst, amp_rst}, 32'h2);
        rd(5'h14, rv);
        chk("R8 status ana", rv, 32'h2);
        wr(5'h00, 32'h4);
        settle();
        chk("R8 amp hold", {30'h0, mod_rst, amp_rst}, 32'h1);
        wr(5'h00, 32'h0);
        rd(5'h14, rv);
        chk("R8 released", rv, 32'h0);

        // R3 R5 R7 burst of three
        wr(5'h10, 32'h1);
        wr(5'h08, 32'd3);
        wr(5'h0C, 32'h1);
        strobes(2);
        settle();
        chk("R3 still running", {30'h0, capture_en, irq}, 32'h2);
        strobes(1);
        settle();
        chk("R3 stopped", {31'h0, capture_en}, 32'h0);
        chk("R7 irq high", {31'h0, irq}, 32'h1);
        rd(5'h14, rv);
        chk("R5 done seen", rv, 32'h1);
        settle();
        chk("R6 irq cleared by read", {31'h0, irq}, 32'h0);
        rd(5'h14, rv);
        chk("R6 done cleared", rv, 32'h0);

        // R7 irq gated by enable
        wr(5'h10, 32'h0);
        wr(5'h08, 32'd1);
        wr(5'h0C, 32'h1);
        strobes(1);
        settle();
        chk("R7 irq masked", {31'h0, irq}, 32'h0);
        rd(5'h14, rv);
        chk("R5 done without irq", rv, 32'h1);
        wr(5'h10, 32'h1);

        // R6 read in the completing cycle
        wr(5'h08, 32'd2);
        wr(5'h0C, 32'h1);
        strobes(1);
        cyc(1'b0, 1'b1, 5'h14, 32'h0, 1'b1, rv);
        chk("R6 same-cycle read", rv, 32'h1);
        settle();
        chk("R6 done kept", {31'h0, irq}, 32'h1);
        rd(5'h14, rv);
        rd(5'h14, rv);
        chk("R6 then cleared", rv, 32'h0);

        // R9 restart needs full count
        wr(5'h08, 32'd4);
        wr(5'h0C, 32'h1);
        strobes(2);
        wr(5'h0C, 32'h0);
        wr(5'h0C, 32'h1);
        strobes(3);
        settle();
        chk("R9 restart counts again", {31'h0, capture_en}, 32'h1);
        strobes(1);
        settle();
        chk("R9 stops at total", {31'h0, capture_en}, 32'h0);
        rd(5'h14, rv);

        // R10 rewrite of run while running
        wr(5'h08, 32'd3);
        wr(5'h0C, 32'h1);
        strobes(2);
        wr(5'h0C, 32'h1);
        strobes(1);
        settle();
        chk("R10 no restart", {31'h0, capture_en}, 32'h0);
        rd(5'h14, rv);

        // R3 total of zero
        wr(5'h08, 32'd0);
        wr(5'h0C, 32'h1);
        strobes(1);
        settle();
        chk("R3 zero total", {31'h0, capture_en}, 32'h0);
        rd(5'h14, rv);
        chk("R3 zero total done", rv, 32'h1);

        // R4 continuous mode
        wr(5'h00, 32'h1);
        wr(5'h08, 32'd2);
        wr(5'h0C, 32'h1);
        strobes(6);
        settle();
        chk("R4 keeps running", {30'h0, capture_en, irq}, 32'h2);
        rd(5'h14, rv);
        chk("R5 no done in continuous", rv, 32'h0);
        wr(5'h0C, 32'h0);
        settle();
        chk("R4 software stop", {31'h0, capture_en}, 32'h0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule